// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block refreshes DRAM rows at rates that depend on how long each row holds its charge, instead of at one worst-case rate for every row. Rows with the shortest retention sit in the fastest bin and are refreshed on every sweep. Rows in the middle bin are refreshed on every second sweep. All other rows fall into a default bin and are refreshed on every fourth sweep. Bin membership is held in small Bloom filters, one per short-retention bin. Software or a start-up sequencer fills these filters with the row addresses that profiling found weak.

An external timer pulses `tick` once per base refresh period. Each tick starts a sweep over all rows in ascending order. The scheduler probes the filters for the current row and combines the result with a sweep counter to decide whether that row is due. For a due row it issues an activate and then a precharge on the command port. Each command waits for an acknowledge before the next step. A Bloom-filter false positive only places a row in a faster bin. It can never slow a row down.

Top module: `rfsh_bin_sched`

## Requirements
- R1: After reset `cmd_valid` is low, both filters are empty and the sweep counter is 0.
- R2: An insertion (`ins_valid` high at a rising edge) sets two bits in the filter chosen by `ins_bin`: 0 selects the fastest bin and 1 selects the middle bin. With an 8-bit hash, bit j of hash A is the XOR of every address bit i where i mod 8 = j. Hash B is built the same way from the bit-reversed address (address bit ROW_W-1-i takes the place of bit i).
- R3: A probe hits a filter only when both of that filter's hashed bits are set. When a row hits both filters, the fastest bin wins.
- R4: The 2-bit sweep counter sets which rows are due. Fastest-bin rows are due in every sweep. Middle-bin rows are due when the counter is even. Default-bin rows are due only when the counter is 0. The counter increments after each completed sweep and wraps from 3 to 0.
- R5: A sweep visits rows 0 to 2^ROW_W-1 in ascending order and issues commands only for rows that are due.
- R6: Each refresh of a row is an activate (`cmd_is_pre` = 0) followed by a precharge (`cmd_is_pre` = 1) to the same `cmd_row`. Each command holds `cmd_valid`, `cmd_is_pre` and `cmd_row` steady until `cmd_ack` is high at a rising edge.
- R7: In the cycle after a precharge is acknowledged, `cmd_valid` is low. The row pointer advances only after that acknowledge.
- R8: A tick that arrives during a sweep is remembered, one deep, and the next sweep starts as soon as the current one ends. Several ticks during one sweep merge into a single extra sweep.
- R9: While no sweep is running and no tick is pending, no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base refresh period pulse; starts or queues a sweep |
| ins_valid | input | 1 | Insert `ins_row` into the filter chosen by `ins_bin` |
| ins_bin | input | 1 | Filter select: 0 = fastest bin, 1 = middle bin |
| ins_row | input | ROW_W | Row address to insert |
| cmd_valid | output | 1 | Refresh command pending |
| cmd_is_pre | output | 1 | 0 = activate, 1 = precharge |
| cmd_row | output | ROW_W | Row address of the pending command |
| cmd_ack | input | 1 | Command accepted at this rising edge |

## Verification
The assertions check the command handshake on every cycle. A command stays stable until it is acknowledged. An acknowledged activate is followed by a precharge to the same row. A command always starts with an activate. `cmd_valid` drops after each precharge acknowledge.

Only the bench scenarios can show which rows are refreshed in each sweep. The bench keeps its own filter model, including false positives, to predict the due rows for every value of the sweep counter. It also checks that ticks arriving mid-sweep produce exactly one extra sweep, and that nothing is issued without a tick.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_SCAN = 2'd1,
        SW_ACT  = 2'd2,
        SW_PRE  = 2'd3
    } sweep_st_e;

endpackage

// File: rtl/rfsh_bloom.sv
module rfsh_bloom #(
    parameter int ROW_W     = 10,
    parameter int FILT_BITS = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [ROW_W-1:0] ins_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             hit
);
    localparam int HW = $clog2(FILT_BITS);

    typedef struct packed {
        logic [FILT_BITS-1:0] bits;
    } bloom_t;

    bloom_t st_q, st_d;

    // Hash A: fold the address onto HW bits by XOR.
    function automatic logic [HW-1:0] hash_a(input logic [ROW_W-1:0] r);
        logic [HW-1:0] h;
        h = '0;
        for (int i = 0; i < ROW_W; i++) begin
            h[i % HW] = h[i % HW] ^ r[i];
        end
        return h;
    endfunction

    // Hash B: the same fold applied to the bit-reversed address.
    function automatic logic [HW-1:0] hash_b(input logic [ROW_W-1:0] r);
        logic [HW-1:0] h;
        h = '0;
        for (int i = 0; i < ROW_W; i++) begin
            h[i % HW] = h[i % HW] ^ r[ROW_W-1-i];
        end
        return h;
    endfunction

    always_comb begin
        st_d = st_q;
        if (ins_en) begin
            st_d.bits[hash_a(ins_row)] = 1'b1;
            st_d.bits[hash_b(ins_row)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = st_q.bits[hash_a(probe_row)] & st_q.bits[hash_b(probe_row)];

endmodule

// File: rtl/rfsh_bin_decide.sv
module rfsh_bin_decide #(
    parameter int NUM_BINS = 2
) (
    input  logic [NUM_BINS-1:0] hit,
    input  logic [NUM_BINS-1:0] period,
    output logic                due
);
    int sel;

    always_comb begin
        // The lowest-index hit picks the shortest interval; no hit means the default bin.
        sel = NUM_BINS;
        for (int i = NUM_BINS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel = i;
            end
        end
        // Bin k has an interval of 2^k sweeps: due when the low k counter bits are zero.
        due = 1'b1;
        for (int i = 0; i < NUM_BINS; i++) begin
            if ((i < sel) && period[i]) begin
                due = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rfsh_sweep_fsm.sv
module rfsh_sweep_fsm
    import rfsh_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int NUM_BINS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cmd_ack,
    input  logic                due,
    output logic [ROW_W-1:0]    ptr,
    output logic [NUM_BINS-1:0] period,
    output logic                cmd_valid,
    output logic                cmd_is_pre
);
    localparam logic [ROW_W-1:0] LAST_ROW = '1;

    typedef struct packed {
        sweep_st_e             st;
        logic [ROW_W-1:0]      ptr;
        logic [NUM_BINS-1:0]   period;
        logic                  pend;
    } fsm_t;

    fsm_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            SW_IDLE: begin
                if (tick || st_q.pend) begin
                    st_d.st   = SW_SCAN;
                    st_d.ptr  = '0;
                    st_d.pend = 1'b0;
                end
            end
            SW_SCAN: begin
                if (tick) st_d.pend = 1'b1;
                if (due) begin
                    st_d.st = SW_ACT;
                end else if (st_q.ptr == LAST_ROW) begin
                    st_d.st     = SW_IDLE;
                    st_d.period = st_q.period + 1'b1;
                end else begin
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end
            SW_ACT: begin
                if (tick) st_d.pend = 1'b1;
                if (cmd_ack) st_d.st = SW_PRE;
            end
            SW_PRE: begin
                if (tick) st_d.pend = 1'b1;
                if (cmd_ack) begin
                    if (st_q.ptr == LAST_ROW) begin
                        st_d.st     = SW_IDLE;
                        st_d.period = st_q.period + 1'b1;
                    end else begin
                        st_d.st  = SW_SCAN;
                        st_d.ptr = st_q.ptr + 1'b1;
                    end
                end
            end
            default: st_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: SW_IDLE, ptr: '0, period: '0, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr        = st_q.ptr;
    assign period     = st_q.period;
    assign cmd_valid  = (st_q.st == SW_ACT) || (st_q.st == SW_PRE);
    assign cmd_is_pre = (st_q.st == SW_PRE);

endmodule

// File: rtl/rfsh_bin_sched.sv
module rfsh_bin_sched #(
    parameter int ROW_W     = 10,
    parameter int FILT_BITS = 256,
    parameter int NUM_BINS  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   tick,
    input  logic                                   ins_valid,
    input  logic [(NUM_BINS>1?$clog2(NUM_BINS):1)-1:0] ins_bin,
    input  logic [ROW_W-1:0]                       ins_row,
    output logic                                   cmd_valid,
    output logic                                   cmd_is_pre,
    output logic [ROW_W-1:0]                       cmd_row,
    input  logic                                   cmd_ack
);
    localparam int BIN_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;

    logic [ROW_W-1:0]    ptr;
    logic [NUM_BINS-1:0] period;
    logic [NUM_BINS-1:0] hit;
    logic                due;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_filt
        rfsh_bloom #(
            .ROW_W     (ROW_W),
            .FILT_BITS (FILT_BITS)
        ) u_bloom (
            .clk       (clk),
            .rst_n     (rst_n),
            .ins_en    (ins_valid && (ins_bin == BIN_W'(b))),
            .ins_row   (ins_row),
            .probe_row (ptr),
            .hit       (hit[b])
        );
    end

    rfsh_bin_decide #(
        .NUM_BINS (NUM_BINS)
    ) u_decide (
        .hit    (hit),
        .period (period),
        .due    (due)
    );

    rfsh_sweep_fsm #(
        .ROW_W    (ROW_W),
        .NUM_BINS (NUM_BINS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmd_ack    (cmd_ack),
        .due        (due),
        .ptr        (ptr),
        .period     (period),
        .cmd_valid  (cmd_valid),
        .cmd_is_pre (cmd_is_pre)
    );

    assign cmd_row = ptr;

endmodule

// File: rtl/rfsh_bin_sched_chk.sv
module rfsh_bin_sched_chk #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_is_pre,
    input logic [ROW_W-1:0] cmd_row,
    input logic             cmd_ack
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !cmd_valid);

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_row) && $stable(cmd_is_pre)));

    assert_act_then_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_is_pre && cmd_ack) |=> (cmd_valid && cmd_is_pre && $stable(cmd_row)));

    assert_start_with_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !$past(cmd_valid)) |-> !cmd_is_pre);

    assert_gap_after_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_pre && cmd_ack) |=> !cmd_valid);

endmodule

bind rfsh_bin_sched rfsh_bin_sched_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_is_pre (cmd_is_pre),
    .cmd_row    (cmd_row),
    .cmd_ack    (cmd_ack)
);

// File: tb/rfsh_bin_sched_tb.sv
module rfsh_bin_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 9;
    localparam int ROWS       = 1 << ROW_W;
    localparam int FBITS      = 256;
    localparam int WDOG       = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             ins_valid = 1'b0;
    logic [0:0]       ins_bin = '0;
    logic [ROW_W-1:0] ins_row = '0;
    logic             cmd_valid;
    logic             cmd_is_pre;
    logic [ROW_W-1:0] cmd_row;
    logic             cmd_ack = 1'b0;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int per_m = 0;
    bit bf [2][FBITS];

    rfsh_bin_sched #(.ROW_W(ROW_W), .FILT_BITS(FBITS), .NUM_BINS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ins_valid(ins_valid),
        .ins_bin(ins_bin), .ins_row(ins_row), .cmd_valid(cmd_valid),
        .cmd_is_pre(cmd_is_pre), .cmd_row(cmd_row), .cmd_ack(cmd_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            total++; fails++;
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, WDOG);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // R2 hash definitions, 8-bit hash
    function automatic int ha(input int r);
        logic [7:0] h = '0;
        for (int i = 0; i < ROW_W; i++) h[i % 8] ^= r[i];
        return int'(h);
    endfunction
    function automatic int hb(input int r);
        logic [7:0] h = '0;
        for (int i = 0; i < ROW_W; i++) h[i % 8] ^= r[ROW_W-1-i];
        return int'(h);
    endfunction
    // R3 R4 due rule
    function automatic bit due_m(input int r, input int p);
        if (bf[0][ha(r)] && bf[0][hb(r)]) return 1'b1;
        if (bf[1][ha(r)] && bf[1][hb(r)]) return (p % 2) == 0;
        return p == 0;
    endfunction

    task automatic ins(input int b, input int r);
        ins_valid = 1'b1; ins_bin = 1'(b); ins_row = ROW_W'(r);
        @(negedge clk);
        ins_valid = 1'b0;
        bf[b][ha(r)] = 1'b1; bf[b][hb(r)] = 1'b1;
    endtask

    task automatic pulse_tick();
        tick = 1'b1; @(negedge clk); tick = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmd_valid) seen = 1'b1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    task automatic wait_ack_phase(input int r, input bit pre);
        int d = int'($urandom_range(0, 2));
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_row == ROW_W'(r) && cmd_is_pre == pre,
                "R6 hold", int'(cmd_row), r);
        end
        cmd_ack = 1'b1; @(negedge clk); cmd_ack = 1'b0;
    endtask

    task automatic serve(input int r, input int mid_ticks);
        int w = 0;
        while (!cmd_valid && w < 3 * ROWS) begin @(negedge clk); w++; end
        chk(cmd_valid, "R5 command expected", int'(cmd_valid), 1);
        chk(cmd_row == ROW_W'(r), "R2 R3 R4 R5 row", int'(cmd_row), r);
        chk(!cmd_is_pre, "R6 activate first", int'(cmd_is_pre), 0);
        for (int t = 0; t < mid_ticks; t++) begin
            pulse_tick(); @(negedge clk);
            chk(cmd_valid && cmd_row == ROW_W'(r), "R6 hold with tick", int'(cmd_row), r);
        end
        wait_ack_phase(r, 1'b0);
        chk(cmd_valid && cmd_is_pre, "R6 precharge follows", int'(cmd_is_pre), 1);
        chk(cmd_row == ROW_W'(r), "R6 precharge row", int'(cmd_row), r);
        wait_ack_phase(r, 1'b1);
        chk(!cmd_valid, "R7 gap after precharge", int'(cmd_valid), 0);
    endtask

    task automatic sweep(input bit do_tick, input int mid_ticks, input bit followon);
        bit first = 1'b1;
        if (do_tick) pulse_tick();
        for (int r = 0; r < ROWS; r++) begin
            if (due_m(r, per_m)) begin
                serve(r, first ? mid_ticks : 0);
                first = 1'b0;
            end
        end
        per_m = (per_m + 1) % 4;
        if (!followon) quiet(ROWS + 8, "R8 R9 no extra command after sweep");
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk(!cmd_valid, "R1 reset cmd_valid", int'(cmd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid, "R1 idle after reset", int'(cmd_valid), 0);
        // fastest bin: directed edges plus random rows
        ins(0, 0); ins(0, ROWS - 1); ins(0, 77);
        for (int i = 0; i < 6; i++) ins(0, int'($urandom_range(0, ROWS - 1)));
        // middle bin: directed, a row in both filters, random rows
        ins(1, 5); ins(1, 300); ins(1, 77);
        for (int i = 0; i < 30; i++) ins(1, int'($urandom_range(0, ROWS - 1)));
        chk(due_m(77, 1), "R3 dual-hit row uses fastest bin", int'(due_m(77, 1)), 1);
        quiet(40, "R9 no command without tick");
        sweep(1'b1, 0, 1'b0);   // counter 0: every row
        sweep(1'b1, 0, 1'b0);   // counter 1: fastest bin
        sweep(1'b1, 0, 1'b0);   // counter 2: fastest and middle
        sweep(1'b1, 0, 1'b0);   // counter 3: fastest
        sweep(1'b1, 2, 1'b1);   // counter 0 again, two ticks mid-sweep merge
        sweep(1'b0, 0, 1'b0);   // R8 follow-on sweep, counter 1
        sweep(1'b1, 0, 1'b0);   // counter 2
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule